// File: doc/BRIEF.md
# Exception and Trap Entry Controller

This block sits beside the pipeline of a small 32-bit processor core and performs the state changes needed to enter an exception, a reserved-instruction fault or a software trap, and to leave one again. It owns an 8-bit status word with an 8-bit backup copy, a backup program counter, a second-level backup program counter and a programmable vector base. When the core raises a request, the block updates those registers on the next clock edge. In the same cycle it emits a one-cycle redirect pulse together with the address the core must fetch from next.

Three entry sources are supported: address exceptions, reserved instructions and trap instructions carrying a 4-bit number. Address exceptions and reserved instructions vector to fixed addresses set by parameters. A trap vectors into a table placed 0x40 bytes above the vector base, with one word per trap number. A return request puts the saved status bits back and pops the second-level backup PC into the backup PC. It also redirects fetch to the saved resume address. The core can write the status word and the vector base directly.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word, its backup, the backup PC, the second-level backup PC and the vector base all read zero, and redirectValid is low.
- R2: An address exception copies the old backup PC into the second-level backup PC and the whole status byte into the backup byte (psw[15:8]). It keeps only bit 7 (stack mode) of the status byte, loads the backup PC with faultPc and redirects to ADDR_EXC_VEC.
- R3: A reserved instruction copies status bits 7 (stack mode), 6 (interrupt enable) and 0 (condition) into the same positions of the backup byte and leaves the other backup bits alone. It clears bits 6 and 0 of the status byte and leaves its other bits alone. It loads the backup PC with faultPc, leaves the second-level backup PC unchanged and redirects to RSVD_VEC.
- R4: A trap with number n redirects to vectorBase + 0x40 + 4*n. It saves the status and the second-level backup PC as in R2, and it loads the backup PC with faultPc with its two low bits cleared, plus 4.
- R5: A return redirects to the backup PC held before it and copies backup bits 7, 6 and 0 into status bits 7, 6 and 0. Other status bits and the backup byte are unchanged, and the backup PC takes the second-level backup PC's value.
- R6: When several requests arrive in one cycle, only one is served, in the priority address exception, then reserved instruction, then trap, then return.
- R7: Every accepted request gives exactly one cycle of redirectValid on the following cycle. Cycles without a request give no pulse and leave all state unchanged.
- R8: A vector base write takes effect on the next edge, and a trap in the same cycle uses the old vector base.
- R9: A status write loads the status byte, but only in a cycle with no entry or return request. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrExcReq | input | 1 | Address exception request |
| rsvdInsnReq | input | 1 | Reserved instruction request |
| trapReq | input | 1 | Trap instruction request |
| trapNum | input | 4 | Trap number |
| rteReq | input | 1 | Return-from-exception request |
| faultPc | input | 32 | PC of the instruction raising the request |
| pswWrEn | input | 1 | Status byte write enable |
| pswWrData | input | 8 | Status byte write data |
| evbWrEn | input | 1 | Vector base write enable |
| evbWrData | input | 32 | Vector base write data |
| redirectValid | output | 1 | One-cycle fetch redirect pulse |
| redirectPc | output | 32 | Fetch redirect address |
| psw | output | 16 | Backup byte (15:8) and status byte (7:0) |
| bpc | output | 32 | Backup PC |
| bbpc | output | 32 | Second-level backup PC |
| evb | output | 32 | Vector base |

## Verification
The hardest case to reach is a return that must restore status bits which differ from the current ones, while leaving non-restored bits visibly untouched. A return straight after entry only restores zeros. The stimulus therefore first sets all status bits through a write and takes an address exception so that the backup byte holds 0xFF. It then writes a different pattern into the status byte before issuing the return, so that restored bits and kept bits can be told apart. Back-to-back traps carrying a same-cycle vector base write, and a status write colliding with a reserved-instruction entry, cover the remaining ordering cases.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PSW_W    = 8;
  localparam int SM_BIT   = 7;
  localparam int IE_BIT   = 6;
  localparam int COND_BIT = 0;

  typedef struct packed {
    logic takeAddr;
    logic takeRsvd;
    logic takeTrap;
    logic takeRte;
    logic wrPsw;
  } excStrobes_t;
endpackage

// File: rtl/exc_entry_ctrl_unit.sv
module exc_entry_ctrl_unit
  import exc_entry_pkg::*;
(
  input  logic        addrExcReq,
  input  logic        rsvdInsnReq,
  input  logic        trapReq,
  input  logic        rteReq,
  input  logic        pswWrEn,
  output excStrobes_t strb
);
  logic anyReq;

  always_comb begin
    strb.takeAddr = addrExcReq;
    strb.takeRsvd = rsvdInsnReq && !addrExcReq;
    strb.takeTrap = trapReq && !addrExcReq && !rsvdInsnReq;
    strb.takeRte  = rteReq && !addrExcReq && !rsvdInsnReq && !trapReq;
    anyReq        = addrExcReq || rsvdInsnReq || trapReq || rteReq;
    strb.wrPsw    = pswWrEn && !anyReq;
  end
endmodule

// File: rtl/exc_entry_datapath.sv
module exc_entry_datapath
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                TRAP_NUM_W   = 4,
  parameter logic [ADDR_W-1:0] ADDR_EXC_VEC = 32'h0000_0030,
  parameter logic [ADDR_W-1:0] RSVD_VEC     = 32'h0000_0020,
  parameter logic [ADDR_W-1:0] TRAP_OFS     = 32'h0000_0040
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  excStrobes_t           strb,
  input  logic [TRAP_NUM_W-1:0] trapNum,
  input  logic [ADDR_W-1:0]     faultPc,
  input  logic [PSW_W-1:0]      pswWrData,
  input  logic                  evbWrEn,
  input  logic [ADDR_W-1:0]     evbWrData,
  output logic                  redirectValid,
  output logic [ADDR_W-1:0]     redirectPc,
  output logic [PSW_W-1:0]      pswByte,
  output logic [PSW_W-1:0]      bpswByte,
  output logic [ADDR_W-1:0]     bpc,
  output logic [ADDR_W-1:0]     bbpc,
  output logic [ADDR_W-1:0]     evb
);
  localparam logic [PSW_W-1:0] KEEP_MASK = PSW_W'(1) << SM_BIT;

  logic [PSW_W-1:0]  pswN, bpswN;
  logic [ADDR_W-1:0] bpcN, bbpcN, pcN, trapVec, retPc;
  logic              vldN;

  assign trapVec = evb + TRAP_OFS + ADDR_W'({trapNum, 2'b00});
  assign retPc   = {faultPc[ADDR_W-1:2], 2'b00} + ADDR_W'(4);

  always_comb begin
    pswN  = pswByte;
    bpswN = bpswByte;
    bpcN  = bpc;
    bbpcN = bbpc;
    pcN   = redirectPc;
    vldN  = 1'b0;
    if (strb.takeAddr || strb.takeTrap) begin
      bbpcN = bpc;
      bpswN = pswByte;
      pswN  = pswByte & KEEP_MASK;
      bpcN  = strb.takeAddr ? faultPc : retPc;
      pcN   = strb.takeAddr ? ADDR_EXC_VEC : trapVec;
      vldN  = 1'b1;
    end else if (strb.takeRsvd) begin
      bpswN[SM_BIT]   = pswByte[SM_BIT];
      bpswN[IE_BIT]   = pswByte[IE_BIT];
      bpswN[COND_BIT] = pswByte[COND_BIT];
      pswN[IE_BIT]    = 1'b0;
      pswN[COND_BIT]  = 1'b0;
      bpcN            = faultPc;
      pcN             = RSVD_VEC;
      vldN            = 1'b1;
    end else if (strb.takeRte) begin
      pswN[SM_BIT]   = bpswByte[SM_BIT];
      pswN[IE_BIT]   = bpswByte[IE_BIT];
      pswN[COND_BIT] = bpswByte[COND_BIT];
      bpcN           = bbpc;
      pcN            = bpc;
      vldN           = 1'b1;
    end else if (strb.wrPsw) begin
      pswN = pswWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pswByte       <= '0;
      bpswByte      <= '0;
      bpc           <= '0;
      bbpc          <= '0;
      evb           <= '0;
      redirectPc    <= '0;
      redirectValid <= 1'b0;
    end else begin
      pswByte       <= pswN;
      bpswByte      <= bpswN;
      bpc           <= bpcN;
      bbpc          <= bbpcN;
      redirectPc    <= pcN;
      redirectValid <= vldN;
      if (evbWrEn) evb <= evbWrData;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                TRAP_NUM_W   = 4,
  parameter logic [ADDR_W-1:0] ADDR_EXC_VEC = 32'h0000_0030,
  parameter logic [ADDR_W-1:0] RSVD_VEC     = 32'h0000_0020,
  parameter logic [ADDR_W-1:0] TRAP_OFS     = 32'h0000_0040
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  addrExcReq,
  input  logic                  rsvdInsnReq,
  input  logic                  trapReq,
  input  logic [TRAP_NUM_W-1:0] trapNum,
  input  logic                  rteReq,
  input  logic [ADDR_W-1:0]     faultPc,
  input  logic                  pswWrEn,
  input  logic [PSW_W-1:0]      pswWrData,
  input  logic                  evbWrEn,
  input  logic [ADDR_W-1:0]     evbWrData,
  output logic                  redirectValid,
  output logic [ADDR_W-1:0]     redirectPc,
  output logic [2*PSW_W-1:0]    psw,
  output logic [ADDR_W-1:0]     bpc,
  output logic [ADDR_W-1:0]     bbpc,
  output logic [ADDR_W-1:0]     evb
);
  excStrobes_t      strb;
  logic [PSW_W-1:0] pswByte, bpswByte;

  exc_entry_ctrl_unit i_ctrl (
    .addrExcReq (addrExcReq),
    .rsvdInsnReq(rsvdInsnReq),
    .trapReq    (trapReq),
    .rteReq     (rteReq),
    .pswWrEn    (pswWrEn),
    .strb       (strb)
  );

  exc_entry_datapath #(
    .ADDR_W      (ADDR_W),
    .TRAP_NUM_W  (TRAP_NUM_W),
    .ADDR_EXC_VEC(ADDR_EXC_VEC),
    .RSVD_VEC    (RSVD_VEC),
    .TRAP_OFS    (TRAP_OFS)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .trapNum      (trapNum),
    .faultPc      (faultPc),
    .pswWrData    (pswWrData),
    .evbWrEn      (evbWrEn),
    .evbWrData    (evbWrData),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc),
    .pswByte      (pswByte),
    .bpswByte     (bpswByte),
    .bpc          (bpc),
    .bbpc         (bbpc),
    .evb          (evb)
  );

  assign psw = {bpswByte, pswByte};
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int                ADDR_W       = 32,
  parameter int                TRAP_NUM_W   = 4,
  parameter logic [ADDR_W-1:0] ADDR_EXC_VEC = 32'h0000_0030,
  parameter logic [ADDR_W-1:0] RSVD_VEC     = 32'h0000_0020,
  parameter logic [ADDR_W-1:0] TRAP_OFS     = 32'h0000_0040
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  addrExcReq,
  input logic                  rsvdInsnReq,
  input logic                  trapReq,
  input logic [TRAP_NUM_W-1:0] trapNum,
  input logic                  rteReq,
  input logic                  redirectValid,
  input logic [ADDR_W-1:0]     redirectPc,
  input logic [15:0]           psw,
  input logic [ADDR_W-1:0]     bpc,
  input logic [ADDR_W-1:0]     bbpc,
  input logic [ADDR_W-1:0]     evb
);
  logic anyReq, rsvdOnly, trapOnly, rteOnly;
  assign anyReq   = addrExcReq || rsvdInsnReq || trapReq || rteReq;
  assign rsvdOnly = rsvdInsnReq && !addrExcReq;
  assign trapOnly = trapReq && !addrExcReq && !rsvdInsnReq;
  assign rteOnly  = rteReq && !addrExcReq && !rsvdInsnReq && !trapReq;

  p_pulse_on_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> redirectValid);
  p_no_pulse_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> !redirectValid && $stable(bpc) && $stable(bbpc));
  p_addr_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrExcReq |=> redirectPc == ADDR_EXC_VEC && bbpc == $past(bpc)
                   && psw[15:8] == $past(psw[7:0]) && psw[7:0] == ($past(psw[7:0]) & 8'h80));
  p_rsvd_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    rsvdOnly |=> redirectPc == RSVD_VEC && psw[7] == $past(psw[7])
                 && !psw[6] && !psw[0] && $stable(bbpc));
  p_trap_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapOnly |=> redirectPc == $past(evb) + TRAP_OFS + ADDR_W'({$past(trapNum), 2'b00}));
  p_rte_restore_r5: assert property (@(posedge clk) disable iff (!rstN)
    rteOnly |=> redirectPc == $past(bpc) && bpc == $past(bbpc) && $stable(psw[15:8]));
endmodule

bind exc_entry_ctrl exc_entry_checker #(
  .ADDR_W      (ADDR_W),
  .TRAP_NUM_W  (TRAP_NUM_W),
  .ADDR_EXC_VEC(ADDR_EXC_VEC),
  .RSVD_VEC    (RSVD_VEC),
  .TRAP_OFS    (TRAP_OFS)
) i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .addrExcReq   (addrExcReq),
  .rsvdInsnReq  (rsvdInsnReq),
  .trapReq      (trapReq),
  .trapNum      (trapNum),
  .rteReq       (rteReq),
  .redirectValid(redirectValid),
  .redirectPc   (redirectPc),
  .psw          (psw),
  .bpc          (bpc),
  .bbpc         (bbpc),
  .evb          (evb)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        addrExcReq, rsvdInsnReq, trapReq, rteReq;
  logic [3:0]  trapNum;
  logic [31:0] faultPc;
  logic        pswWrEn;
  logic [7:0]  pswWrData;
  logic        evbWrEn;
  logic [31:0] evbWrData;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic [15:0] psw;
  logic [31:0] bpc, bbpc, evb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rstN(rstN),
    .addrExcReq(addrExcReq), .rsvdInsnReq(rsvdInsnReq), .trapReq(trapReq),
    .trapNum(trapNum), .rteReq(rteReq), .faultPc(faultPc),
    .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .evbWrEn(evbWrEn), .evbWrData(evbWrData),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .psw(psw), .bpc(bpc), .bbpc(bbpc), .evb(evb)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    addrExcReq = 0; rsvdInsnReq = 0; trapReq = 0; rteReq = 0;
    trapNum = 0; faultPc = 0; pswWrEn = 0; pswWrData = 0;
    evbWrEn = 0; evbWrData = 0;
  endtask

  // Inputs are set before calling; one edge passes, sampling at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic doReset();
    rstN = 0;
    idleInputs();
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic writePsw(logic [7:0] v);
    pswWrEn = 1; pswWrData = v;
    tick();
  endtask

  task automatic testReset();
    doReset();
    check("R1", "psw", 32'(psw), 0);
    check("R1", "bpc", bpc, 0);
    check("R1", "bbpc", bbpc, 0);
    check("R1", "evb", evb, 0);
    check("R1", "redirectValid", 32'(redirectValid), 0);
  endtask

  task automatic testAddrExc();
    writePsw(8'hC1);
    check("R9", "psw after write", 32'(psw), 32'h00C1);
    addrExcReq = 1; faultPc = 32'h1000;
    tick();
    check("R2", "redirectValid", 32'(redirectValid), 1);
    check("R2", "redirectPc", redirectPc, 32'h30);
    check("R2", "psw", 32'(psw), 32'hC180);
    check("R2", "bpc", bpc, 32'h1000);
    check("R2", "bbpc", bbpc, 0);
    tick();
    check("R7", "pulse ends", 32'(redirectValid), 0);
    check("R7", "idle psw stable", 32'(psw), 32'hC180);
    addrExcReq = 1; faultPc = 32'h2000;
    tick();
    check("R2", "second psw", 32'(psw), 32'h8080);
    check("R2", "second bbpc", bbpc, 32'h1000);
    check("R2", "second bpc", bpc, 32'h2000);
  endtask

  task automatic testRsvd();
    writePsw(8'h5F);
    rsvdInsnReq = 1; faultPc = 32'h3004;
    tick();
    check("R3", "redirectPc", redirectPc, 32'h20);
    check("R3", "psw", 32'(psw), 32'h411E);
    check("R3", "bpc", bpc, 32'h3004);
    check("R3", "bbpc unchanged", bbpc, 32'h1000);
  endtask

  task automatic testTrap();
    evbWrEn = 1; evbWrData = 32'h8000;
    tick();
    check("R8", "evb written", evb, 32'h8000);
    trapReq = 1; trapNum = 4'd5; faultPc = 32'h4006;
    tick();
    check("R4", "vector n=5", redirectPc, 32'h8054);
    check("R4", "bpc", bpc, 32'h4008);
    check("R4", "bbpc", bbpc, 32'h3004);
    check("R4", "psw", 32'(psw), 32'h1E00);
    trapReq = 1; trapNum = 4'd15; faultPc = 32'h5003;
    evbWrEn = 1; evbWrData = 32'h9000;
    tick();
    check("R8", "trap uses old evb", redirectPc, 32'h807C);
    check("R8", "evb updated", evb, 32'h9000);
    check("R4", "second bpc", bpc, 32'h5004);
    check("R4", "second bbpc", bbpc, 32'h4008);
  endtask

  task automatic testRte();
    writePsw(8'hFF);
    addrExcReq = 1; faultPc = 32'h6000;
    tick();
    writePsw(8'h02);
    check("R9", "psw before return", 32'(psw), 32'hFF02);
    rteReq = 1;
    tick();
    check("R5", "redirectPc", redirectPc, 32'h6000);
    check("R5", "psw restored", 32'(psw), 32'hFFC3);
    check("R5", "bpc popped", bpc, 32'h5004);
    check("R5", "bbpc kept", bbpc, 32'h5004);
  endtask

  task automatic testPriority();
    evbWrEn = 1; evbWrData = 32'h0;
    tick();
    addrExcReq = 1; rsvdInsnReq = 1; trapReq = 1; rteReq = 1; trapNum = 4'd1;
    tick();
    check("R6", "address exception wins", redirectPc, 32'h30);
    rsvdInsnReq = 1; trapReq = 1; rteReq = 1; trapNum = 4'd1;
    tick();
    check("R6", "reserved beats trap", redirectPc, 32'h20);
    trapReq = 1; rteReq = 1; trapNum = 4'd2;
    tick();
    check("R6", "trap beats return", redirectPc, 32'h48);
    check("R7", "single pulse", 32'(redirectValid), 1);
    tick();
    check("R7", "no pulse when idle", 32'(redirectValid), 0);
  endtask

  task automatic testPswCollision();
    doReset();
    writePsw(8'h80);
    rsvdInsnReq = 1; pswWrEn = 1; pswWrData = 8'h7F;
    tick();
    check("R9", "write dropped under entry", 32'(psw), 32'h8080);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testAddrExc();
    testRsvd();
    testTrap();
    testRte();
    testPriority();
    testPswCollision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule